// File: doc/BRIEF.md
# Star-Delta Motor Starter Sequencer

This block sequences the contactors of a three-phase motor that is started in star connection and switched to delta once a programmable delay has run out. Its state is a four-bit marking with one bit each for the idle place, the main-contactor-plus-timer place, the star place and the delta place. While the motor is starting, the main and star places are marked together. While it runs, the main and delta places are marked together.

The operator inputs are a start push button wired as a normally-open contact and a stop push button wired as a normally-closed contact. A thermal overload relay, also a normally-closed contact, is the third input. An open stop or overload circuit is treated as a stop demand. Each raw input passes through a two-flop synchronizer before the sequencer uses it. The block drives three contactor coils (main, star, delta) and three indicator lamps: green while idle, yellow during star, red during delta. The star delay is counted in clock cycles by an internal counter.

Top module: `star_delta_starter`

## Requirements
- R1: During and after reset, `placeMarking` is 4'b1000 (bit 3 idle, bit 2 main/timer, bit 1 star, bit 0 delta). Only the green lamp is lit and no coil is energized.
- R2: In idle, a start demand (`startNo` high) with no halt moves the marking to 4'b0110. This happens on the third rising edge after the input change: two synchronizer stages, then the marking register. The main and star coils and the yellow lamp turn on.
- R3: The marking stays 4'b0110 for exactly `STAR_DELAY` cycles. It then becomes 4'b0101: star drops, delta closes, main stays on, and the red lamp is lit.
- R4: A stop demand (`stopNc` low) during star returns the marking to 4'b1000, three edges after the input change.
- R5: A stop demand or an overload (`overloadNc` low) during delta returns the marking to 4'b1000, three edges after the input change.
- R6: An overload during star returns the marking to 4'b1000.
- R7: If a stop demand or an overload is present together with start in idle, the marking stays 4'b1000.
- R8: The star and delta coils are never energized together. Exactly one lamp is lit at any time.
- R9: A start demand during star or delta has no effect on the marking or on the delay already running.
- R10: The delay counter restarts from zero each time star is entered, so a restart after an aborted start again lasts the full `STAR_DELAY` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startNo | input | 1 | Start button, normally open; 1 = pressed |
| stopNc | input | 1 | Stop button, normally closed; 0 = stop demand |
| overloadNc | input | 1 | Overload contact, normally closed; 0 = overload |
| mainCoil | output | 1 | Main contactor coil |
| starCoil | output | 1 | Star contactor coil |
| deltaCoil | output | 1 | Delta contactor coil |
| greenLamp | output | 1 | Idle indicator |
| yellowLamp | output | 1 | Star indicator |
| redLamp | output | 1 | Delta indicator |
| placeMarking | output | 4 | Marking {idle, main/timer, star, delta} |

## Verification
The coils and lamps are decoded directly from the marking register. A wrong marking therefore appears at the pins in the same cycle the register takes it, and the bench compares every output against the expected marking at specific cycles. A delay counter that is off by one moves the star-to-delta switch by one cycle. Because the bench checks both the last star cycle and the first delta cycle, that shift is caught. A counter that fails to clear shows up as a short star phase after an aborted start.

// File: rtl/sd_pkg.sv
package sd_pkg;
  localparam int MARK_W = 4;
  localparam logic [MARK_W-1:0] MARK_IDLE  = 4'b1000;
  localparam logic [MARK_W-1:0] MARK_STAR  = 4'b0110;
  localparam logic [MARK_W-1:0] MARK_DELTA = 4'b0101;
  localparam int BIT_IDLE  = 3;
  localparam int BIT_MAIN  = 2;
  localparam int BIT_STAR  = 1;
  localparam int BIT_DELTA = 0;

  typedef struct packed {
    logic clear;  // restart the delay count
    logic run;    // advance the delay count
  } timerStrobe_t;
endpackage

// File: rtl/sd_sync.sv
module sd_sync #(
  parameter int WIDTH = 3,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] rawIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stageA;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stageA[i]  <= RESET_VAL[i];
        syncOut[i] <= RESET_VAL[i];
      end else begin
        stageA[i]  <= rawIn[i];
        syncOut[i] <= stageA[i];
      end
    end
  end
endmodule

// File: rtl/sd_delay_timer.sv
module sd_delay_timer
  import sd_pkg::*;
#(
  parameter int STAR_DELAY = 1000
) (
  input  logic         clk,
  input  logic         rstN,
  input  timerStrobe_t strobe,
  output logic         delayDone
);
  localparam int CNT_W = $clog2(STAR_DELAY + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STAR_DELAY - 1);

  logic [CNT_W-1:0] count;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (strobe.clear) begin
      count <= '0;
    end else if (strobe.run && count != LAST) begin
      count <= count + 1'b1;
    end
  end

  assign delayDone = strobe.run && (count == LAST);

  // Count never passes the final delay cycle (R3)
  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    count <= LAST);
  // A clear always lands the counter at zero (R10)
  assert_clear_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> count == '0);
endmodule

// File: rtl/sd_sequencer.sv
module sd_sequencer
  import sd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              haltReq,
  input  logic              delayDone,
  output timerStrobe_t      strobe,
  output logic [MARK_W-1:0] marking
);
  logic [MARK_W-1:0] nextMarking;

  always_comb begin
    nextMarking = marking;
    unique case (marking)
      MARK_IDLE:  if (startReq && !haltReq) nextMarking = MARK_STAR;
      MARK_STAR: begin
        if (haltReq)        nextMarking = MARK_IDLE;
        else if (delayDone) nextMarking = MARK_DELTA;
      end
      MARK_DELTA: if (haltReq) nextMarking = MARK_IDLE;
      default:    nextMarking = MARK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) marking <= MARK_IDLE;
    else       marking <= nextMarking;
  end

  always_comb begin
    strobe.clear = (marking == MARK_IDLE) && (nextMarking == MARK_STAR);
    strobe.run   = (marking == MARK_STAR);
  end

  // Star and delta bits never marked together (R8)
  assert_star_delta_excl_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(marking[BIT_STAR] && marking[BIT_DELTA]));
  // Delta is entered only from star (R3)
  assert_delta_from_star_R3: assert property (@(posedge clk) disable iff (!rstN)
    (marking == MARK_DELTA && $past(marking) != MARK_DELTA) |-> $past(marking) == MARK_STAR);
  // A halt in any active place returns to idle (R4, R5, R6)
  assert_halt_to_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    (marking != MARK_IDLE && haltReq) |=> marking == MARK_IDLE);
  // Halt blocks a start from idle (R7)
  assert_halt_blocks_start_R7: assert property (@(posedge clk) disable iff (!rstN)
    (marking == MARK_IDLE && haltReq) |=> marking == MARK_IDLE);
endmodule

// File: rtl/star_delta_starter.sv
module star_delta_starter
  import sd_pkg::*;
#(
  parameter int STAR_DELAY = 1000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startNo,
  input  logic       stopNc,
  input  logic       overloadNc,
  output logic       mainCoil,
  output logic       starCoil,
  output logic       deltaCoil,
  output logic       greenLamp,
  output logic       yellowLamp,
  output logic       redLamp,
  output logic [3:0] placeMarking
);
  logic [2:0] syncIn;
  logic       delayDone;
  timerStrobe_t strobe;
  logic [MARK_W-1:0] marking;

  // Reset value 0 on all three: no start, stop and overload asserted
  sd_sync #(.WIDTH(3), .RESET_VAL(3'b000)) i_sync (
    .clk(clk), .rstN(rstN),
    .rawIn({startNo, stopNc, overloadNc}),
    .syncOut(syncIn)
  );

  sd_sequencer i_seq (
    .clk(clk), .rstN(rstN),
    .startReq(syncIn[2]),
    .haltReq(!syncIn[1] || !syncIn[0]),
    .delayDone(delayDone),
    .strobe(strobe),
    .marking(marking)
  );

  sd_delay_timer #(.STAR_DELAY(STAR_DELAY)) i_timer (
    .clk(clk), .rstN(rstN),
    .strobe(strobe),
    .delayDone(delayDone)
  );

  assign placeMarking = marking;
  assign mainCoil     = marking[BIT_MAIN];
  assign starCoil     = marking[BIT_STAR];
  assign deltaCoil    = marking[BIT_DELTA];
  assign greenLamp    = marking[BIT_IDLE];
  assign yellowLamp   = marking[BIT_STAR];
  assign redLamp      = marking[BIT_DELTA];

  // Exactly one lamp lit (R8)
  assert_lamp_onehot_R8: assert property (@(posedge clk) disable iff (!rstN)
    $countones({greenLamp, yellowLamp, redLamp}) == 1);
endmodule

// File: tb/test_star_delta_starter.sv
module test_star_delta_starter;
  localparam int CLK_PERIOD = 10;
  localparam int DLY = 12;
  localparam logic [3:0] IDLE = 4'b1000;
  localparam logic [3:0] STAR = 4'b0110;
  localparam logic [3:0] DELT = 4'b0101;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startNo = 1'b0, stopNc = 1'b1, overloadNc = 1'b1;
  logic mainCoil, starCoil, deltaCoil, greenLamp, yellowLamp, redLamp;
  logic [3:0] placeMarking;

  int cyc = 0;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  typedef struct { int at; logic [3:0] mark; int req; } expItem_t;
  expItem_t sbQueue[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  star_delta_starter #(.STAR_DELAY(DLY)) i_star_delta_starter (
    .clk(clk), .rstN(rstN), .startNo(startNo), .stopNc(stopNc),
    .overloadNc(overloadNc), .mainCoil(mainCoil), .starCoil(starCoil),
    .deltaCoil(deltaCoil), .greenLamp(greenLamp), .yellowLamp(yellowLamp),
    .redLamp(redLamp), .placeMarking(placeMarking)
  );

  task automatic pushAt(int at, logic [3:0] mark, int req);
    expItem_t it;
    it.at = at; it.mark = mark; it.req = req;
    sbQueue.push_back(it);
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: pops scoreboard entries on their cycle and compares all outputs
  always @(negedge clk) begin
    while (sbQueue.size() > 0 && sbQueue[0].at == cyc) begin
      expItem_t it;
      logic [6:0] act, exp;
      it = sbQueue.pop_front();
      act = {placeMarking, mainCoil, starCoil, deltaCoil};
      exp = {it.mark, it.mark[2], it.mark[1], it.mark[0]};
      total++;
      if (act !== exp || {greenLamp, yellowLamp, redLamp} !== {it.mark[3], it.mark[1], it.mark[0]}) begin
        bad++;
        $display("FAIL R%0d cycle %0d: actual mark=%b coils=%b lamps=%b expected mark=%b",
                 it.req, cyc, placeMarking, {mainCoil, starCoil, deltaCoil},
                 {greenLamp, yellowLamp, redLamp}, it.mark);
      end
    end
    // R8: star and delta coils never both on
    if (rstN && starCoil && deltaCoil) begin
      total++; bad++;
      $display("FAIL R8 cycle %0d: actual star=1 delta=1 expected not both", cyc);
    end
  end

  // Start pulse of one cycle; returns the drive cycle
  task automatic pulseStart(output int t0);
    startNo = 1'b1; t0 = cyc; step(1); startNo = 1'b0;
  endtask

  initial begin
    int t;
    step(3);
    pushAt(cyc + 1, IDLE, 1);  // R1 during reset
    step(2);
    rstN = 1'b1;
    pushAt(cyc + 1, IDLE, 1);  // R1 after reset
    pushAt(cyc + 4, IDLE, 1);
    step(5);

    // R7: start with stop, then start with overload
    startNo = 1'b1; stopNc = 1'b0; t = cyc;
    pushAt(t + 3, IDLE, 7); pushAt(t + 5, IDLE, 7);
    step(6);
    stopNc = 1'b1; overloadNc = 1'b0; t = cyc;
    pushAt(t + 3, IDLE, 7); pushAt(t + 5, IDLE, 7);
    step(6);
    startNo = 1'b0; overloadNc = 1'b1;
    step(5);

    // R2 then R3, with a repeated start during star (R9)
    pulseStart(t);
    pushAt(t + 2, IDLE, 2); pushAt(t + 3, STAR, 2);
    step(4);
    startNo = 1'b1; step(1); startNo = 1'b0;  // R9 start in star
    pushAt(t + 3 + DLY - 1, STAR, 3); pushAt(t + 3 + DLY, DELT, 3);
    step(DLY + 2);
    // R9: start during delta has no effect
    startNo = 1'b1; pushAt(cyc + 4, DELT, 9); step(1); startNo = 1'b0;
    step(5);
    // R5: stop in delta
    stopNc = 1'b0; t = cyc; pushAt(t + 2, DELT, 5); pushAt(t + 3, IDLE, 5);
    step(1); stopNc = 1'b1;
    step(5);

    // R4: stop in star, then R10 full delay after restart
    pulseStart(t);
    pushAt(t + 3, STAR, 4);
    step(5);
    stopNc = 1'b0; t = cyc; pushAt(t + 3, IDLE, 4);
    step(1); stopNc = 1'b1;
    step(5);
    pulseStart(t);
    pushAt(t + 3 + DLY - 1, STAR, 10); pushAt(t + 3 + DLY, DELT, 10);
    step(DLY + 5);
    // R5: overload in delta
    overloadNc = 1'b0; t = cyc; pushAt(t + 3, IDLE, 5);
    step(1); overloadNc = 1'b1;
    step(5);

    // R6: overload in star
    pulseStart(t);
    pushAt(t + 3, STAR, 6);
    step(6);
    overloadNc = 1'b0; t = cyc; pushAt(t + 2, STAR, 6); pushAt(t + 3, IDLE, 6);
    pushAt(t + 3 + DLY, IDLE, 6);
    step(1); overloadNc = 1'b1;
    step(DLY + 6);

    while (sbQueue.size() > 0) step(1);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: actual run still busy expected finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule